// File: doc/BRIEF.md
# Dual-Pattern Overlapping Sequence Detector

This block watches a one-bit serial stream and raises a flag when the four most recently accepted bits, oldest first, form either 1001 or 1111. Both patterns are recognised by one merged state machine. Each state records only the part of the recent history that can still lead to a hit, so matches may overlap: the bits that close one match can open the next one.

A bit is accepted on a rising clock edge only while the qualifier `bit_valid` is high. The flag is a registered Moore output and depends only on the state. It goes high in the cycle that follows the edge that accepted the last bit of a match. The current state code is brought out so that a bench can observe it. The reset is asynchronous and active-low. Its release is synchronised inside the block, so the detector leaves reset a fixed number of edges after `rst_n` rises.

Top module: `seq_pair_detector`

## Requirements
- R1: After the edge that accepts the fourth bit of the sequence 1, 0, 0, 1 (oldest first), `match_o` is 1 and `state_o` is 3'd6 until the next accepted bit.
- R2: After the edge that accepts the fourth bit of four consecutive 1s, `match_o` is 1 and `state_o` is 3'd7 until the next accepted bit.
- R3: For every other history of accepted bits, `match_o` is 0. This includes the case where fewer than four bits have been accepted since reset.
- R4: Overlapping matches are found. The stream 1001001 gives a hit after its 4th and 7th bits. A run of seven 1s gives hits after bits 4, 5, 6 and 7.
- R5: While `bit_valid` is 0, the state and `match_o` hold their values, whatever `serial_in` does.
- R6: While `rst_n` is 0, `match_o` is 0 and `state_o` is 3'd0 (empty history). Bits accepted before reset never count toward a match. After `rst_n` rises, bits are accepted once SYNC_STAGES rising edges have passed.
- R7: `state_o` is 3 bits wide. Code 3'd0 means empty history, 3'd6 means a 1001 hit and 3'd7 means a 1111 hit.
- R8: In every cycle, `match_o` is 1 exactly when `state_o` holds one of the two hit codes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_valid | input | 1 | Accept `serial_in` on this edge |
| serial_in | input | 1 | Serial data bit |
| match_o | output | 1 | High while the last four accepted bits are 1001 or 1111 |
| state_o | output | 3 | Current state code of the detector |

## Verification
In one cycle, a completed match can also be the first part of the next one. Examples are the trailing 1 of 1001, or a fifth 1 after 1111. A hit for one pattern can also be followed directly by a hit for the other. The bench provokes these cases with directed overlap streams and with long random streams biased toward 1s. It compares every cycle against a four-bit shift-register model that counts accepted bits since reset. Where the model expects a hit, it also checks that `state_o` carries the hit code of the pattern that matched.

// File: rtl/seqdet_pkg.sv
`timescale 1ns/1ps
package seqdet_pkg;
  localparam int STATE_W = 3;

  // Each code names the useful suffix of the accepted history.
  typedef enum logic [STATE_W-1:0] {
    ST_EMPTY = 3'd0,  // nothing that can lead to a hit
    ST_1     = 3'd1,  // ...1 (not 11)
    ST_10    = 3'd2,  // ...10
    ST_100   = 3'd3,  // ...100
    ST_11    = 3'd4,  // ...11 (not 111)
    ST_111   = 3'd5,  // ...111
    ST_HIT_A = 3'd6,  // 1001 just completed, tail 1 kept
    ST_HIT_B = 3'd7   // 1111 just completed, tail 111 kept
  } det_state_e;

  function automatic logic is_hit(det_state_e s);
    return (s == ST_HIT_A) || (s == ST_HIT_B);
  endfunction
endpackage

// File: rtl/seqdet_rst_sync.sv
`timescale 1ns/1ps
module seqdet_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] sync_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= 1'b1;
      end
    end else begin : g_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[LAST-1:0], 1'b1};
      end
    end
  endgenerate

  assign rst_n_sync = sync_q[LAST];
endmodule

// File: rtl/seqdet_next.sv
`timescale 1ns/1ps
module seqdet_next
  import seqdet_pkg::*;
(
  input  det_state_e cur,
  input  logic       bit_in,
  output det_state_e nxt
);
  always_comb begin
    nxt = ST_EMPTY;
    unique case (cur)
      ST_EMPTY: nxt = bit_in ? ST_1     : ST_EMPTY;
      ST_1:     nxt = bit_in ? ST_11    : ST_10;
      ST_10:    nxt = bit_in ? ST_1     : ST_100;
      ST_100:   nxt = bit_in ? ST_HIT_A : ST_EMPTY;
      ST_11:    nxt = bit_in ? ST_111   : ST_10;
      ST_111:   nxt = bit_in ? ST_HIT_B : ST_10;
      ST_HIT_A: nxt = bit_in ? ST_11    : ST_10;
      ST_HIT_B: nxt = bit_in ? ST_HIT_B : ST_10;
      default:  nxt = ST_EMPTY;
    endcase
  end
endmodule

// File: rtl/seqdet_regs.sv
`timescale 1ns/1ps
module seqdet_regs
  import seqdet_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  det_state_e nxt,
  output det_state_e state_q,
  output logic       hit_q
);
  logic hit_d;

  assign hit_d = is_hit(nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_EMPTY;
      hit_q   <= 1'b0;
    end else if (en) begin
      state_q <= nxt;
      hit_q   <= hit_d;
    end
  end
endmodule

// File: rtl/seq_pair_detector.sv
`timescale 1ns/1ps
module seq_pair_detector
  import seqdet_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_valid,
  input  logic               serial_in,
  output logic               match_o,
  output logic [STATE_W-1:0] state_o
);
  logic       rst_n_int;
  det_state_e cur_state;
  det_state_e nxt_state;

  seqdet_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  seqdet_next u_next (
    .cur    (cur_state),
    .bit_in (serial_in),
    .nxt    (nxt_state)
  );

  seqdet_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .en      (bit_valid),
    .nxt     (nxt_state),
    .state_q (cur_state),
    .hit_q   (match_o)
  );

  assign state_o = cur_state;
endmodule

// File: rtl/seq_pair_detector_chk.sv
`timescale 1ns/1ps
module seq_pair_detector_chk
  import seqdet_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               bit_valid,
  input logic               serial_in,
  input logic               match_o,
  input logic [STATE_W-1:0] state_o
);
  // R1: 100 followed by an accepted 1 lands in the 1001 hit state
  a_r1_hit_1001: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_100 && bit_valid && serial_in) |=> (state_o == ST_HIT_A && match_o));

  // R2: 111 followed by an accepted 1 lands in the 1111 hit state
  a_r2_hit_1111: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_111 && bit_valid && serial_in) |=> (state_o == ST_HIT_B && match_o));

  // R4: a further 1 after 1111 keeps the hit
  a_r4_run_of_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_HIT_B && bit_valid && serial_in) |=> match_o);

  // R3: one accepted bit from an empty history cannot give a hit
  a_r3_no_early_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == ST_EMPTY && bit_valid) |=> !match_o);

  // R5: no accepted bit, nothing changes
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_valid |=> ($stable(state_o) && $stable(match_o)));

  // R6: coming out of reset the history is empty
  a_r6_empty_on_release: assert property (@(posedge clk)
    $rose(rst_n) |-> (state_o == ST_EMPTY && !match_o));

  // R8: flag agrees with the hit codes
  a_r8_moore_flag: assert property (@(posedge clk) disable iff (!rst_n)
    match_o == (state_o == ST_HIT_A || state_o == ST_HIT_B));
endmodule

bind seq_pair_detector seq_pair_detector_chk u_chk (.*);

// File: tb/seq_pair_detector_bench.sv
`timescale 1ns/1ps
module seq_pair_detector_bench;
  localparam int SYNC = 2;

  typedef struct {
    logic  exp_match;
    logic  [3:0] hist;
    logic  hold;
    string tag;
  } exp_item_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_valid = 1'b0;
  logic       serial_in = 1'b0;
  logic       match_o;
  logic [2:0] state_o;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  exp_item_t q[$];
  logic [3:0] m_hist = 4'b0;
  int         m_cnt  = 0;
  logic [2:0] last_state = 3'd0;

  always #10 clk = ~clk;  // 50 MHz

  seq_pair_detector #(.SYNC_STAGES(SYNC)) u_seq_pair_detector (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_valid (bit_valid),
    .serial_in (serial_in),
    .match_o   (match_o),
    .state_o   (state_o)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Driver: one item per cycle, expected values from a shift-register model
  task automatic drive_bit(input logic v, input logic b, input string tag);
    exp_item_t it;
    @(negedge clk);
    bit_valid = v;
    serial_in = b;
    if (v) begin
      m_hist = {m_hist[2:0], b};
      if (m_cnt < 4) m_cnt++;
    end
    it.exp_match = (m_cnt >= 4) && (m_hist == 4'b1001 || m_hist == 4'b1111);
    it.hist = m_hist;
    it.hold = !v;
    it.tag  = tag;
    q.push_back(it);
  endtask

  task automatic drive_pattern(input logic [15:0] bits, input int n, input string tag);
    for (int i = n - 1; i >= 0; i--) drive_bit(1'b1, bits[i], tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    bit_valid = 1'b0;
    m_hist = 4'b0;
    m_cnt = 0;
    repeat (3) @(negedge clk);
    check(match_o == 1'b0, "R6", "flag in reset", match_o, 0);
    check(state_o == 3'd0, "R6", "state in reset", state_o, 0);
    rst_n = 1'b1;
    for (int i = 0; i < SYNC + 2; i++) drive_bit(1'b0, 1'b1, "R6");
  endtask

  // Monitor: compare each cycle, away from the edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (q.size() > 0) begin
        exp_item_t it;
        string t;
        it = q.pop_front();
        t = it.exp_match ? ((it.hist == 4'b1001) ? "R1" : "R2") : it.tag;
        check(match_o == it.exp_match, t, "match_o", match_o, it.exp_match);
        check(match_o == (state_o == 3'd6 || state_o == 3'd7), "R8", "flag vs code",
              match_o, (state_o == 3'd6 || state_o == 3'd7));
        if (it.exp_match && it.hist == 4'b1001)
          check(state_o == 3'd6, "R7", "state after 1001", state_o, 6);
        if (it.exp_match && it.hist == 4'b1111)
          check(state_o == 3'd7, "R7", "state after 1111", state_o, 7);
        if (it.hold)
          check(state_o == last_state, "R5", "state held", state_o, last_state);
      end
      last_state = state_o;
    end
  end

  initial begin
    #(20 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R3: a hit needs four accepted bits
    drive_pattern(16'b001, 3, "R3");
    drive_pattern(16'b1001, 4, "R1");
    // R4: overlapping 1001
    do_reset();
    drive_pattern(16'b1001001, 7, "R4");
    // R4: run of seven ones
    do_reset();
    drive_pattern(16'b1111111, 7, "R4");
    // R4: 1111 then 1001 sharing bits, and 1001 then 111
    drive_pattern(16'b001111, 6, "R4");
    // R5: idle cycles with toggling data change nothing
    drive_pattern(16'b100, 3, "R5");
    for (int i = 0; i < 5; i++) drive_bit(1'b0, i[0], "R5");
    drive_bit(1'b1, 1'b1, "R5");
    drive_pattern(16'b111, 3, "R5");
    for (int i = 0; i < 4; i++) drive_bit(1'b0, 1'b0, "R5");
    drive_bit(1'b1, 1'b1, "R5");
    // R6: history before reset does not count
    drive_pattern(16'b111, 3, "R6");
    do_reset();
    drive_pattern(16'b1, 1, "R6");
    drive_pattern(16'b001, 3, "R6");
    // R3: other four-bit values never hit
    do_reset();
    for (int v = 0; v < 16; v++) drive_pattern(v[3:0], 4, "R3");
    // Random streams, biased toward ones, with gaps
    for (int r = 0; r < 3; r++) begin
      do_reset();
      for (int i = 0; i < 3000; i++)
        drive_bit(($urandom % 8) != 0, ($urandom % 4) != 0, "R3");
    end
    drive_bit(1'b0, 1'b0, "R5");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule